// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Back-to-Back Mode

This block turns parallel data words into frames on a single asynchronous line. The line idles high. A frame is one low start bit, then the data bits from least to most significant, then one high stop bit. Every bit holds the line for a number of clock cycles set by a divisor input. A zero divisor counts as one. The divisor is sampled when a frame starts and holds for the whole frame.

A request input asks for a frame. A busy output stays high while a frame is on the line. A single-cycle done output marks the last cycle of the stop bit.

A mode input selects when the data word is taken:

- **Mode off:** the word is captured on the clock edge that accepts the request. A request that arrives while a frame is in progress is dropped. At least one idle cycle therefore separates two frames.
- **Mode on:** a request made during a frame is remembered. The next start bit then follows the stop bit with no idle cycle. The data word for that chained frame is captured on the edge where its start bit begins.

Top module: `serial_tx`

## Requirements
- R1: After reset the line output is high, busy is low and done is low.
- R2: A frame is one low start bit, then DATA_W data bits with bit 0 first, then one high stop bit. Each bit lasts max(divisor,1) cycles. The start bit appears in the cycle after the edge that accepts the request.
- R3: Busy is high in every cycle of a frame, from the start bit through the stop bit. Whenever busy is low, the line is high.
- R4: Done is high for exactly one cycle, the last cycle of the stop bit, and is low at all other times.
- R5: With the mode input low, the data word is captured on the edge that accepts the request. Later changes to the data input do not alter that frame.
- R6: With the mode input low, a request made while busy is ignored, including in the done cycle. The line stays idle after the frame, and the next frame needs a request while idle.
- R7: With the mode input high, a request made while busy, including in the done cycle, starts the next start bit in the cycle right after the stop bit ends. Only one further frame follows.
- R8: With the mode input high, a chained frame carries the data input's value from the last stop-bit cycle, the edge where its start bit begins. Values presented earlier are not used.
- R9: The divisor is sampled when a frame starts. Changing it during a frame does not change that frame's bit timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_i | input | DIV_W | Bit period in clock cycles (0 treated as 1) |
| cont_i | input | 1 | Back-to-back mode: high captures data at start-bit time |
| ack_i | input | 1 | Transmit request |
| data_i | input | DATA_W | Word to send |
| line_o | output | 1 | Serial line, idles high |
| busy_o | output | 1 | High while a frame is on the line |
| done_o | output | 1 | One-cycle pulse in the last stop-bit cycle |

## Verification
The bench sweeps every data word at divisors 0 through 4. A design that sent the most significant bit first, or treated a zero divisor as a long period, would show a wrong line level in some cycle.

Several cases target the handshake edges:

- **Mode off, done cycle:** a request raised in the done cycle must be dropped. A design that restarts there would remove the idle cycle.
- **Mode off, mid-frame:** a request and a divisor change during a frame must have no effect. A design that honours them would cut the frame short or alter its timing.
- **Mode on, chaining:** the chained frame must start with no gap. It must carry the word presented in the last stop cycle, not the word presented with the request. A design that captures at request time, or waits an idle cycle, fails these checks.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } tx_state_e;

  // Effective bit period: a zero divisor behaves as one cycle per bit.
  function automatic int unsigned eff_div(input int unsigned d);
    return (d == 0) ? 1 : d;
  endfunction

  // Clock cycles occupied by one frame (start + data + stop).
  function automatic int unsigned frame_cycles(input int unsigned nbits,
                                               input int unsigned d);
    return (nbits + 2) * eff_div(d);
  endfunction

endpackage

// File: rtl/serial_tx_timer.sv
module serial_tx_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] period_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == period_i - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else if (run_i)   cnt_q <= cnt_q + DIV_W'(1);
  end

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q < period_i));

endmodule

// File: rtl/serial_tx_shifter.sv
module serial_tx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_i,
  output logic              bit_o
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       sh_q <= '0;
    else if (load_i)  sh_q <= data_i;
    else if (shift_i) sh_q <= sh_q >> 1;
  end

  assign bit_o = sh_q[0];

endmodule

// File: rtl/serial_tx_ctrl.sv
module serial_tx_ctrl
  import serial_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ack_i,
  input  logic      cont_i,
  input  logic      tick_i,
  output tx_state_e state_o,
  output logic      start_o,
  output logic      shift_o,
  output logic      busy_o,
  output logic      done_o
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  tx_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic             pend_q;

  // Named internal events
  logic idle, frame_end, chain;

  assign idle      = (state_q == ST_IDLE);
  assign frame_end = (state_q == ST_STOP) && tick_i;
  assign chain     = frame_end && cont_i && (pend_q || ack_i);

  assign start_o = (idle && ack_i) || chain;
  assign shift_o = (state_q == ST_DATA) && tick_i;
  assign busy_o  = !idle;
  assign done_o  = frame_end;
  assign state_o = state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (frame_end)                   pend_q <= 1'b0;
      else if (!idle && cont_i && ack_i) pend_q <= 1'b1;

      case (state_q)
        ST_IDLE:  if (ack_i) state_q <= ST_START;
        ST_START: if (tick_i) begin
                    state_q <= ST_DATA;
                    idx_q   <= '0;
                  end
        ST_DATA:  if (tick_i) begin
                    if (idx_q == LAST_IDX) state_q <= ST_STOP;
                    else                   idx_q   <= idx_q + IDX_W'(1);
                  end
        ST_STOP:  if (tick_i) state_q <= chain ? ST_START : ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  // R6
  drop_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !cont_i) |=> !busy_o);

  // R7
  chain_nogap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && cont_i && ack_i) |=> (state_o == ST_START));

endmodule

// File: rtl/serial_tx.sv
module serial_tx
  import serial_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              cont_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              line_o,
  output logic              busy_o,
  output logic              done_o
);
  tx_state_e        state;
  logic             start_evt, shift_evt, tick, data_bit;
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         div_q <= DIV_W'(1);
    else if (start_evt) div_q <= DIV_W'(eff_div(32'(div_i)));
  end

  serial_tx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ack_i   (ack_i),
    .cont_i  (cont_i),
    .tick_i  (tick),
    .state_o (state),
    .start_o (start_evt),
    .shift_o (shift_evt),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  serial_tx_timer #(.DIV_W(DIV_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (start_evt),
    .run_i    (busy_o),
    .period_i (div_q),
    .tick_o   (tick)
  );

  serial_tx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (start_evt),
    .data_i  (data_i),
    .shift_i (shift_evt),
    .bit_o   (data_bit)
  );

  always_comb begin
    case (state)
      ST_START: line_o = 1'b0;
      ST_DATA:  line_o = data_bit;
      default:  line_o = 1'b1;
    endcase
  end

  // R3
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> line_o);

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !line_o);

  // R4
  done_in_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (line_o && busy_o));

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R3
  busy_end_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(done_o));

endmodule

// File: tb/serial_tx_bench.sv
module serial_tx_bench;
  localparam int DW = 8;
  localparam int VW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cont = 1'b0;
  logic          ack = 1'b0;
  logic [DW-1:0] data = '0;
  logic [VW-1:0] div = VW'(1);
  logic          line, busy, done;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  serial_tx #(.DATA_W(DW), .DIV_W(VW)) u_serial_tx (
    .clk(clk), .rst_n(rst_n), .div_i(div), .cont_i(cont), .ack_i(ack),
    .data_i(data), .line_o(line), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_line(input int d, input int slot);
    if (slot == 0) return 0;
    if (slot <= DW) return (d >> (slot - 1)) & 1;
    return 1;
  endfunction

  // Called at the negedge of the first start-bit cycle; returns at the
  // negedge one cycle after the stop bit ends.
  task automatic check_frame(input int d, input int dv, input string req);
    int ed;
    ed = (dv == 0) ? 1 : dv;
    for (int slot = 0; slot < DW + 2; slot++) begin
      for (int c = 0; c < ed; c++) begin
        chk(line == exp_line(d, slot), req, "line", int'(line), exp_line(d, slot));
        chk(busy == 1'b1, "R3", "busy in frame", int'(busy), 1);
        chk(done == ((slot == DW + 1) && (c == ed - 1)), "R4", "done",
            int'(done), int'((slot == DW + 1) && (c == ed - 1)));
        @(negedge clk);
      end
    end
  endtask

  task automatic check_idle(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      chk(line == 1'b1, req, "idle line", int'(line), 1);
      chk(busy == 1'b0, req, "idle busy", int'(busy), 0);
      chk(done == 1'b0, "R4", "idle done", int'(done), 0);
      @(negedge clk);
    end
  endtask

  // Called at a negedge while idle.
  task automatic send_idle(input int d, input int dv, input string req);
    data = DW'(d);
    div  = VW'(dv);
    ack  = 1'b1;
    @(negedge clk);
    ack  = 1'b0;
    data = ~DW'(d);   // R5: later change must not matter
    check_frame(d, dv, req);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(line == 1'b1, "R1", "reset line", int'(line), 1);
    chk(busy == 1'b0, "R1", "reset busy", int'(busy), 0);
    chk(done == 1'b0, "R1", "reset done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle(2, "R1");

    // R2 R5: every word at divisors 0..4, mode off
    for (int dv = 0; dv <= 4; dv++) begin
      for (int d = 0; d < (1 << DW); d++) begin
        send_idle(d, dv, "R2/R5");
        check_idle(1, "R3");
      end
    end

    // R6 R9: request and divisor change mid-frame are ignored
    cont = 1'b0;
    fork
      send_idle(8'hA5, 3, "R9");
      begin
        repeat (7) @(negedge clk);
        ack = 1'b1; data = 8'h3C; div = VW'(1);
        @(negedge clk);
        ack = 1'b0;
      end
    join
    check_idle(3, "R6");

    // R6: request in the done cycle is dropped; one idle cycle precedes restart
    fork
      send_idle(8'h4E, 2, "R2");
      begin
        do @(negedge clk); while (!done);
        ack = 1'b1; data = 8'h96;
      end
    join
    chk(busy == 1'b0, "R6", "gap busy", int'(busy), 0);
    chk(line == 1'b1, "R6", "gap line", int'(line), 1);
    @(negedge clk);
    ack = 1'b0;
    check_frame(8'h96, 2, "R6");
    check_idle(2, "R6");

    // R7 R8: mode on, request mid-frame, data taken at start-bit time
    cont = 1'b1;
    fork
      send_idle(8'h5A, 2, "R2");
      begin
        repeat (5) @(negedge clk);
        ack = 1'b1; data = 8'hFF;
        @(negedge clk);
        ack = 1'b0; data = 8'h00;
        do @(negedge clk); while (!done);
        data = 8'hC3;
      end
    join
    check_frame(8'hC3, 2, "R8");
    check_idle(3, "R7");

    // R7: mode on, request in the done cycle chains without gap
    fork
      send_idle(8'h11, 1, "R2");
      begin
        do @(negedge clk); while (!done);
        ack = 1'b1; data = 8'h81;
        @(negedge clk);
        ack = 1'b0; data = 8'h00;
      end
    join
    check_frame(8'h81, 1, "R7");
    check_idle(3, "R7");
    cont = 1'b0;

    summary();
    $finish;
  end

endmodule